// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the control front end of a single-ported, clocked burst SRAM with a 32-bit data path. On every rising clock edge it looks at the chip selects, two address strobes, an advance input, the write controls and a sleep input. It classifies the edge as one of six operations: idle, deselect, begin burst, continue burst, suspend burst or sleep. It then performs at most one access to a behavioural storage array.

The two strobes do not have the same write permission. The processor strobe always starts a read. The controller strobe starts a read or a write, depending on the write inputs. A write may also follow on any non-strobed cycle of an open burst. A burst address counter steps through a four-word group in linear order and wraps inside it. Read data is registered. An asynchronous output enable, which is masked after writes, decides whether the data bus is driven. A sleep input stops all operations. After the input is released, operations stay stopped for a fixed number of edges.

Top module: `sram_burst_ctrl`

## Requirements
- R1: An edge that samples the processor strobe low while the device is selected (ce_a_ni low, ce_b_i high, ce_c_ni low) starts a read burst, whatever gwr_ni, bwe_ni and be_ni are.
- R2: The write request is true when gwr_ni is low, or when bwe_ni is low and at least one bit of be_ni is low. Otherwise the cycle is a read.
- R3: A write is performed only on an edge with the controller strobe low (and the processor strobe high) while selected, or on a non-strobed edge while a burst is open.
- R4: Begin-burst edges access addr_i. Continue and suspend edges access the internal burst address.
- R5: On a non-strobed edge of an open burst, adv_ni low moves the burst address to the next word, and adv_ni high keeps the address.
- R6: data_oe_o is high only when oe_ni is low and the previous edge performed a read. It follows oe_ni with no clock, and it is low after a write edge.
- R7: An edge is blocked while sleep_i is high and for WAKE_CYC (default 2) edges after sleep_i is sampled low. A blocked edge performs no access and closes any open burst.
- R8: A strobed edge while not selected is a deselect: no access, the burst is closed and data_oe_o goes low.
- R9: A continue edge increments only address bits [1:0], modulo 4. Bits above them are unchanged: 7 -> 4, 9 -> 10.
- R10: Read data for the address used at an edge appears on rdata_o after that edge. It holds the array content from before any write on that edge.
- R11: While the device is blocked, array contents are kept and strobes issued then cause no write.
- R12: With gwr_ni high, a write updates only the lanes whose be_ni bit is low. Lane i is wdata_i[8i+7:8i]. With gwr_ni low, all four lanes are written.
- R13: After reset, data_oe_o is low and no burst is open, so a non-strobed edge performs no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | External word address |
| ce_a_ni | input | 1 | Chip select, active low |
| ce_b_i | input | 1 | Chip select, active high |
| ce_c_ni | input | 1 | Chip select, active low |
| padr_stb_ni | input | 1 | Processor address strobe, active low |
| cadr_stb_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gwr_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| be_ni | input | DW/8 | Per-lane write enables, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Snooze request, active high |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Registered read data |
| data_oe_o | output | 1 | Data bus drive enable |

## Verification
The bench targets these corner cases:

- **Processor strobe with every write input asserted.** A design that let the write inputs win there would write the array, and data_oe_o would stay low.
- **Four-word wrap from the last word of a group.** A counter that carried into bit 2 would read the next group.
- **Write edges that follow a read.** A design that did not mask the output enable would drive the bus after a write edge.
- **Controller-strobe writes in the edges just after sleep_i is released.** A design with too short a wake window would corrupt a word that a later read returns.
- **Deselects, suspends and partial byte-lane writes.** These are mixed into long random traffic that is checked against a bench model of the array.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
  typedef enum logic [2:0] {
    OP_IDLE, OP_DESEL, OP_BEGIN, OP_CONT, OP_SUSP, OP_SLEEP
  } op_e;
endpackage

// File: rtl/sram_cmd_dec.sv
module sram_cmd_dec
  import sram_burst_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic padr_i,
  input  logic cadr_i,
  input  logic adv_i,
  input  logic wr_req_i,
  input  logic active_i,
  input  logic blocked_i,
  output op_e  op_o,
  output logic do_wr_o,
  output logic do_rd_o
);
  always_comb begin
    op_o    = OP_IDLE;
    do_wr_o = 1'b0;
    do_rd_o = 1'b0;
    if (blocked_i) begin
      op_o = OP_SLEEP;
    end else if (padr_i || cadr_i) begin
      if (!sel_i) begin
        op_o = OP_DESEL;
      end else begin
        op_o    = OP_BEGIN;
        // processor strobe always reads
        do_wr_o = !padr_i && wr_req_i;
        do_rd_o = padr_i || !wr_req_i;
      end
    end else if (active_i) begin
      op_o    = adv_i ? OP_CONT : OP_SUSP;
      do_wr_o = wr_req_i;
      do_rd_o = !wr_req_i;
    end
  end

  // R1
  padr_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (padr_i && sel_i && !blocked_i) |-> (do_rd_o && !do_wr_o));
  // R7
  blocked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked_i |-> !(do_wr_o || do_rd_o));
endmodule

// File: rtl/sram_burst_ctr.sv
module sram_burst_ctr #(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] ld_addr_i,
  output logic [AW-1:0] cur_addr_o
);
  logic [AW-1:0] burst_q;
  logic [1:0]    nxt_lo;

  assign nxt_lo = burst_q[1:0] + 2'd1;

  always_comb begin
    if (load_i)      cur_addr_o = ld_addr_i;
    else if (step_i) cur_addr_o = {burst_q[AW-1:2], nxt_lo};
    else             cur_addr_o = burst_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              burst_q <= '0;
    else if (load_i || step_i) burst_q <= cur_addr_o;
  end

  // R9
  wrap_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (burst_q[1:0] == $past(burst_q[1:0]) + 2'd1)
                         && (burst_q[AW-1:2] == $past(burst_q[AW-1:2])));
  // R5
  hold_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(burst_q));
endmodule

// File: rtl/sram_snooze.sv
module sram_snooze #(
  parameter int WAKE_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  output logic blocked_o
);
  localparam int CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] WAKE_LD = CW'(WAKE_CYC);

  logic [CW-1:0] wake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            wake_q <= '0;
    else if (sleep_i)       wake_q <= WAKE_LD;
    else if (wake_q != '0)  wake_q <= wake_q - 1'b1;
  end

  assign blocked_o = sleep_i || (wake_q != '0);

  // R7
  wake_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_i) |-> blocked_o);
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW/8-1:0] lane_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int LANES = DW / 8;
  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    logic [7:0] rd_lane;
    always_ff @(posedge clk_i) begin
      if (wr_i && lane_we_i[l]) lane_mem[addr_i] <= wdata_i[8*l +: 8];
      if (rd_i)                 rd_lane <= lane_mem[addr_i];
    end
    assign rdata_o[8*l +: 8] = rd_lane;
  end
endmodule

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
  import sram_burst_pkg::*;
#(
  parameter int AW       = 6,
  parameter int DW       = 32,
  parameter int WAKE_CYC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic            ce_a_ni,
  input  logic            ce_b_i,
  input  logic            ce_c_ni,
  input  logic            padr_stb_ni,
  input  logic            cadr_stb_ni,
  input  logic            adv_ni,
  input  logic            gwr_ni,
  input  logic            bwe_ni,
  input  logic [DW/8-1:0] be_ni,
  input  logic            oe_ni,
  input  logic            sleep_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            data_oe_o
);
  localparam int LANES = DW / 8;

  logic sel, wr_req, blocked, do_wr, do_rd, active_q, rd_valid_q;
  logic [LANES-1:0] lane_we;
  logic [AW-1:0]    cur_addr;
  op_e              op;

  assign sel     = !ce_a_ni && ce_b_i && !ce_c_ni;
  assign wr_req  = !gwr_ni || (!bwe_ni && !(&be_ni));
  assign lane_we = !gwr_ni ? {LANES{1'b1}} : ~be_ni;

  sram_snooze #(.WAKE_CYC(WAKE_CYC)) u_snooze (
    .clk_i, .rst_ni, .sleep_i, .blocked_o(blocked)
  );

  sram_cmd_dec u_dec (
    .clk_i, .rst_ni,
    .sel_i     (sel),
    .padr_i    (!padr_stb_ni),
    .cadr_i    (!cadr_stb_ni),
    .adv_i     (!adv_ni),
    .wr_req_i  (wr_req),
    .active_i  (active_q),
    .blocked_i (blocked),
    .op_o      (op),
    .do_wr_o   (do_wr),
    .do_rd_o   (do_rd)
  );

  sram_burst_ctr #(.AW(AW)) u_ctr (
    .clk_i, .rst_ni,
    .load_i    (op == OP_BEGIN),
    .step_i    (op == OP_CONT),
    .ld_addr_i (addr_i),
    .cur_addr_o(cur_addr)
  );

  sram_array #(.AW(AW), .DW(DW)) u_mem (
    .clk_i,
    .addr_i   (cur_addr),
    .wr_i     (do_wr),
    .rd_i     (do_rd),
    .lane_we_i(lane_we),
    .wdata_i,
    .rdata_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= do_rd;
      if (op == OP_BEGIN)                          active_q <= 1'b1;
      else if (op == OP_DESEL || op == OP_SLEEP)   active_q <= 1'b0;
    end
  end

  // output enable is asynchronous; masked by the registered read flag
  assign data_oe_o = rd_valid_q && !oe_ni;

  // R6
  wr_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_wr |=> !data_oe_o);
  // R8
  desel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_DESEL) |=> (!data_oe_o && !active_q));
  // R3
  wr_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_wr && padr_stb_ni && cadr_stb_ni) |-> active_q);
endmodule

// File: tb/sim_sram_burst_ctrl.sv
module sim_sram_burst_ctrl;
  logic        clk = 0, rst_ni = 0;
  logic [5:0]  addr = '0;
  logic        ce_a_n = 0, ce_b = 1, ce_c_n = 0;
  logic        padr_n = 1, cadr_n = 1, adv_n = 1, gw_n = 1, bwe_n = 1, oe_n = 0, sleep = 0;
  logic [3:0]  be_n = 4'hF;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        data_oe;

  int total = 0, bad = 0;
  string tag = "R13";

  logic [31:0] m_mem [64];
  logic [5:0]  m_burst = '0;
  logic        m_act = 0, m_rv = 0;
  logic [31:0] m_rd = '0;
  int          m_cnt = 0;

  always #4 clk = ~clk;

  sram_burst_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr),
    .ce_a_ni(ce_a_n), .ce_b_i(ce_b), .ce_c_ni(ce_c_n),
    .padr_stb_ni(padr_n), .cadr_stb_ni(cadr_n), .adv_ni(adv_n),
    .gwr_ni(gw_n), .bwe_ni(bwe_n), .be_ni(be_n), .oe_ni(oe_n),
    .sleep_i(sleep), .wdata_i(wdata), .rdata_o(rdata), .data_oe_o(data_oe)
  );

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    padr_n = 1; cadr_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; be_n = 4'hF;
    ce_a_n = 0; ce_b = 1; ce_c_n = 0; oe_n = 0; sleep = 0;
  endtask

  // bench model of one edge, then check outputs after the edge
  task automatic step();
    logic sel, st, blk, wq, wr, rd;
    logic [5:0] a;
    sel = !ce_a_n && ce_b && !ce_c_n;
    st  = !padr_n || !cadr_n;
    blk = sleep || (m_cnt != 0);
    wq  = !gw_n || (!bwe_n && (be_n != 4'hF));
    wr = 0; rd = 0; a = m_burst;
    if (blk) m_act = 0;
    else if (st) begin
      if (!sel) m_act = 0;
      else begin
        a = addr; m_burst = addr; m_act = 1;
        wr = padr_n && wq; rd = !wr;
      end
    end else if (m_act) begin
      if (!adv_n) m_burst[1:0] = m_burst[1:0] + 2'd1;
      a = m_burst; wr = wq; rd = !wq;
    end
    if (rd) m_rd = m_mem[a];
    m_rv = rd;
    if (wr)
      for (int l = 0; l < 4; l++)
        if (!gw_n || !be_n[l]) m_mem[a][8*l +: 8] = wdata[8*l +: 8];
    m_cnt = sleep ? 2 : (m_cnt != 0 ? m_cnt - 1 : 0);
    @(posedge clk); #2;
    chk("data_oe", {31'd0, data_oe}, {31'd0, m_rv && !oe_n});
    if (m_rv && !oe_n) chk("rdata", rdata, m_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    repeat (3) @(posedge clk); #2;
    tag = "R13";
    chk("reset data_oe", {31'd0, data_oe}, 32'd0);
    rst_ni = 1;
    @(posedge clk); #2;
    adv_n = 0; step();  // R13: no open burst, nothing happens
    idle();

    // fill the array with controller-strobe full writes (R2, R12)
    tag = "R2";
    for (int i = 0; i < 64; i++) begin
      cadr_n = 0; gw_n = 0; addr = 6'(i); wdata = $urandom; step();
    end
    idle();

    // burst write from 8, continue over 9..11, wrap to 8 with a single-lane write
    tag = "R12";
    cadr_n = 0; gw_n = 0; addr = 6'd8; wdata = 32'hA5A5_0001; step();
    cadr_n = 1;
    for (int i = 0; i < 3; i++) begin adv_n = 0; wdata = 32'h1000 + i; step(); end
    gw_n = 1; bwe_n = 0; be_n = 4'b1110; wdata = 32'h1234_56FF; step();  // R9 wrap -> 8, lane 0 only
    idle();

    // R1: processor strobe with every write input asserted still reads
    tag = "R1";
    padr_n = 0; gw_n = 0; bwe_n = 0; be_n = 4'h0; addr = 6'd8; wdata = 32'hDEAD_BEEF; step();
    chk("read after lane write", rdata, 32'hA5A5_00FF);
    idle();

    // R6: asynchronous output enable
    tag = "R6";
    oe_n = 1; #1; chk("oe high", {31'd0, data_oe}, 32'd0);
    oe_n = 0; #1; chk("oe low", {31'd0, data_oe}, 32'd1);

    // R9: continue reads wrap inside the group 8..11
    tag = "R9";
    for (int i = 0; i < 5; i++) begin adv_n = 0; step(); end
    // R5: suspend holds the address
    tag = "R5";
    adv_n = 1; step(); step();
    // R3: write follows a processor-strobe load (suspended address)
    tag = "R3";
    gw_n = 0; wdata = 32'h0BAD_CAFE; step();
    chk("oe after write", {31'd0, data_oe}, 32'd0);
    idle(); step();
    // R10: read back begins with external address
    tag = "R10";
    padr_n = 0; addr = 6'd9; step();
    idle();

    // R8: deselect
    tag = "R8";
    padr_n = 0; ce_b = 0; addr = 6'd3; step();
    idle(); adv_n = 0; step();

    // R7/R11: sleep, then writes during wake window are ignored
    tag = "R7";
    sleep = 1; cadr_n = 0; gw_n = 0; addr = 6'd3; wdata = 32'hFFFF_0000;
    step(); step(); step();
    sleep = 0; step(); step();
    tag = "R11";
    idle(); padr_n = 0; addr = 6'd3; step();
    idle(); step();

    // R4 and mixed random traffic
    tag = "R4";
    for (int n = 0; n < 3000; n++) begin
      int r;
      idle();
      r = int'($urandom % 16);
      if (r < 2) padr_n = 0;
      else if (r < 4) cadr_n = 0;
      ce_b   = ($urandom % 10) != 0;
      ce_a_n = ($urandom % 12) == 0;
      adv_n  = $urandom % 2;
      gw_n   = ($urandom % 4) != 0;
      bwe_n  = $urandom % 2;
      be_n   = 4'($urandom);
      oe_n   = ($urandom % 8) == 0;
      sleep  = ($urandom % 60) == 0;
      addr   = 6'($urandom);
      wdata  = $urandom;
      step();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule